// File: doc/BRIEF.md
# Mailbox Command Message Engine

This block is the host-side end of a byte-wide mailbox shared with an embedded controller. A caller hands it one request: an opcode, a module identifier, a 16-bit payload length and the payload itself. The payload is fetched byte by byte through a small indexed buffer port. The engine frames the request as a four-byte header followed by the payload. It pushes each byte into the mailbox only while the mailbox reports room.

When the caller asks for a reply, the engine then reads a four-byte reply header and checks it against the opcode, module and length the caller expects. A matching reply has its payload streamed out one byte per read. A reply that does not match is read out and thrown away, using the length the reply itself carries, so the next exchange starts on a clean frame boundary. Every single byte transfer polls its mailbox flag at a fixed interval and gives up after a bounded wait. Both times are given in clock cycles by parameters.

The caller sees a start/busy/done handshake and a two-bit result code.

Top module: `mbox_engine`

## Requirements
- R1: The header goes out before any payload, as four bytes in this order: opcode, module ID, length bits 15..8, length bits 7..0.
- R2: Right after the header, exactly `reqLen` payload bytes are written. Byte k is the `txData` value presented while `txIdx` equals k, and the bytes go out for k = 0, 1, 2 in rising order.
- R3: `mbWrEn` is asserted only in cycles where `mbFull` is low. A full mailbox delays the write without losing or repeating a byte.
- R4: `mbRdEn` is asserted only in cycles where `mbEmpty` is low. Only bits 7..0 of `mbRdData` are used, and the upper bits have no effect on any result.
- R5: With `waitReply` high, a reply header whose opcode, module ID and 16-bit length all equal `expOpcode`, `expModule` and `expLen` is accepted. Each of its payload bytes is then presented on `rxByte` with `rxValid` high, in order, and the result code is 0 (OK).
- R6: If any of the three reply header fields differs from the expected value, the engine reads and discards exactly as many bytes as the received length field states. It reads none beyond that, never raises `rxValid`, and returns result code 1 (mismatch).
- R7: A waiting transfer samples its flag once every `POLL_CYC` cycles. If the flag is still blocking at a sample taken after at least `TIMEOUT_CYC` cycles of waiting on that byte, the request ends with result code 2 (timeout).
- R8: A discard phase that times out ends with result code 2. The engine then returns to idle and accepts and completes a new request normally.
- R9: `start` is taken only while idle. `busy` stays high from the cycle after `start` through the single `done` cycle. `done` is a one-cycle pulse, and `status` changes only as `done` rises and holds its value until the next `done`.
- R10: With `waitReply` low, the request completes after its last payload byte is written, and no mailbox read takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (sampled while idle) |
| reqOpcode | input | 8 | Opcode of the outgoing request |
| reqModule | input | 8 | Module ID of the outgoing request |
| reqLen | input | 16 | Payload length of the outgoing request |
| waitReply | input | 1 | Read and check a reply after sending |
| expOpcode | input | 8 | Expected reply opcode |
| expModule | input | 8 | Expected reply module ID |
| expLen | input | 16 | Expected reply payload length |
| txIdx | output | 16 | Index of the payload byte being requested |
| txData | input | 8 | Payload byte at `txIdx` (combinational) |
| mbFull | input | 1 | Mailbox cannot take a byte |
| mbWrEn | output | 1 | Write strobe into the mailbox |
| mbWrData | output | 8 | Byte written into the mailbox |
| mbEmpty | input | 1 | Mailbox holds no byte for the host |
| mbRdEn | output | 1 | Read strobe, pops one mailbox word |
| mbRdData | input | RD_W | Front mailbox word (first-word fall-through) |
| rxValid | output | 1 | Reply payload byte valid |
| rxByte | output | 8 | Reply payload byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 0 OK, 1 mismatch, 2 timeout |

## Verification
The assertions assume the mailbox changes its flags and front word only between rising edges. They also assume the front word is valid in the same cycle that `mbEmpty` is low, and that `txData` follows `txIdx` combinationally. The bench's mailbox model keeps to this: it samples the strobes at the falling edge, applies pushes, pops and stall counts just after the rising edge, and preloads each reply before `start`. Stimulus raises `start` only while `busy` is low. Every reply word carries non-zero upper bits, so any use of them shows up as a wrong byte.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int LEN_W = 16;
  localparam int CNT_W = LEN_W + 1;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_MISMATCH = 2'd1,
    ST_TIMEOUT  = 2'd2
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_TX, S_RXH, S_CHK, S_RXP, S_DRN, S_DONE
  } state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    loadReq;
    logic    clrCnt;
    logic    incCnt;
    logic    pollRestart;
    logic    selRead;
    logic    wr;
    logic    rd;
    logic    capHdr;
    logic    emitRx;
    logic    setStatus;
    status_e statusVal;
  } strobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic ready;
    logic expired;
    logic txLast;
    logic hdrLast;
    logic payLast;
    logic rxLenZero;
    logic hdrMatch;
    logic waitReply;
  } cond_t;
endpackage

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int POLL_CYC    = 1000,
  parameter int TIMEOUT_CYC = 5000000,
  parameter int RD_W        = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output cond_t            cond,
  input  logic [7:0]       reqOpcode,
  input  logic [7:0]       reqModule,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             waitReply,
  input  logic [7:0]       expOpcode,
  input  logic [7:0]       expModule,
  input  logic [LEN_W-1:0] expLen,
  output logic [LEN_W-1:0] txIdx,
  input  logic [7:0]       txData,
  input  logic             mbFull,
  output logic             mbWrEn,
  output logic [7:0]       mbWrData,
  input  logic             mbEmpty,
  output logic             mbRdEn,
  input  logic [RD_W-1:0]  mbRdData,
  output logic             rxValid,
  output logic [7:0]       rxByte,
  output logic [1:0]       status
);
  localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [PW-1:0] POLL_RELOAD = PW'(POLL_CYC - 1);
  localparam logic [TW-1:0] WAIT_MAX    = TW'(TIMEOUT_CYC);
  localparam int HDR_BYTES = 4;

  // latched request
  logic [7:0]       opQ, modQ, expOpQ, expModQ;
  logic [LEN_W-1:0] lenQ, expLenQ;
  logic             waitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= '0; modQ <= '0; lenQ <= '0; waitQ <= 1'b0;
      expOpQ <= '0; expModQ <= '0; expLenQ <= '0;
    end else if (strb.loadReq) begin
      opQ <= reqOpcode; modQ <= reqModule; lenQ <= reqLen; waitQ <= waitReply;
      expOpQ <= expOpcode; expModQ <= expModule; expLenQ <= expLen;
    end
  end

  // shared byte counter
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrCnt) cnt <= '0;
    else if (strb.incCnt)     cnt <= cnt + CNT_W'(1);
  end

  // poll interval and per-byte wait timer
  logic [PW-1:0] pollCnt;
  logic [TW-1:0] waitCnt;
  always_ff @(posedge clk) begin
    if (!rstN || strb.pollRestart) begin
      pollCnt <= '0;
      waitCnt <= '0;
    end else begin
      pollCnt <= (pollCnt == '0) ? POLL_RELOAD : pollCnt - PW'(1);
      if (waitCnt != WAIT_MAX) waitCnt <= waitCnt + TW'(1);
    end
  end

  logic blocked, polled;
  assign blocked = strb.selRead ? mbEmpty : mbFull;
  assign polled  = (pollCnt == '0);

  // reply header capture
  logic [7:0] rxHdr [HDR_BYTES];
  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (!rstN) rxHdr[g] <= '0;
      else if (strb.capHdr && cnt[1:0] == 2'(g)) rxHdr[g] <= mbRdData[7:0];
    end
  end

  logic [LEN_W-1:0] rxLen;
  assign rxLen = {rxHdr[2], rxHdr[3]};

  logic [RD_W-9:0] unusedHi;
  assign unusedHi = mbRdData[RD_W-1:8];

  // outgoing byte select
  always_comb begin
    if (cnt < CNT_W'(HDR_BYTES)) begin
      unique case (cnt[1:0])
        2'd0:    mbWrData = opQ;
        2'd1:    mbWrData = modQ;
        2'd2:    mbWrData = lenQ[15:8];
        default: mbWrData = lenQ[7:0];
      endcase
    end else begin
      mbWrData = txData;
    end
  end

  assign txIdx   = cnt[LEN_W-1:0] - LEN_W'(HDR_BYTES);
  assign mbWrEn  = strb.wr;
  assign mbRdEn  = strb.rd;
  assign rxValid = strb.emitRx;
  assign rxByte  = mbRdData[7:0];

  always_comb begin
    cond.ready     = polled && !blocked;
    cond.expired   = polled && blocked && (waitCnt >= WAIT_MAX);
    cond.txLast    = (cnt == ({1'b0, lenQ} + CNT_W'(HDR_BYTES - 1)));
    cond.hdrLast   = (cnt == CNT_W'(HDR_BYTES - 1));
    cond.payLast   = (cnt == ({1'b0, rxLen} - CNT_W'(1)));
    cond.rxLenZero = (rxLen == '0);
    cond.hdrMatch  = (rxHdr[0] == expOpQ) && (rxHdr[1] == expModQ) && (rxLen == expLenQ);
    cond.waitReply = waitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               status <= ST_OK;
    else if (strb.setStatus) status <= strb.statusVal;
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  cond_t   cond,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      S_IDLE: begin
        strb.pollRestart = 1'b1;
        if (start) begin
          strb.loadReq = 1'b1;
          strb.clrCnt  = 1'b1;
          nxt          = S_TX;
        end
      end
      S_TX: begin
        if (cond.ready) begin
          strb.wr = 1'b1; strb.incCnt = 1'b1; strb.pollRestart = 1'b1;
          if (cond.txLast) begin
            strb.clrCnt = 1'b1;
            if (cond.waitReply) nxt = S_RXH;
            else begin
              strb.setStatus = 1'b1; strb.statusVal = ST_OK; nxt = S_DONE;
            end
          end
        end else if (cond.expired) begin
          strb.setStatus = 1'b1; strb.statusVal = ST_TIMEOUT; nxt = S_DONE;
        end
      end
      S_RXH: begin
        strb.selRead = 1'b1;
        if (cond.ready) begin
          strb.rd = 1'b1; strb.capHdr = 1'b1; strb.incCnt = 1'b1; strb.pollRestart = 1'b1;
          if (cond.hdrLast) begin
            strb.clrCnt = 1'b1;
            nxt         = S_CHK;
          end
        end else if (cond.expired) begin
          strb.setStatus = 1'b1; strb.statusVal = ST_TIMEOUT; nxt = S_DONE;
        end
      end
      S_CHK: begin
        strb.pollRestart = 1'b1;
        if (cond.hdrMatch) begin
          if (cond.rxLenZero) begin
            strb.setStatus = 1'b1; strb.statusVal = ST_OK; nxt = S_DONE;
          end else nxt = S_RXP;
        end else begin
          if (cond.rxLenZero) begin
            strb.setStatus = 1'b1; strb.statusVal = ST_MISMATCH; nxt = S_DONE;
          end else nxt = S_DRN;
        end
      end
      S_RXP: begin
        strb.selRead = 1'b1;
        if (cond.ready) begin
          strb.rd = 1'b1; strb.emitRx = 1'b1; strb.incCnt = 1'b1; strb.pollRestart = 1'b1;
          if (cond.payLast) begin
            strb.setStatus = 1'b1; strb.statusVal = ST_OK; nxt = S_DONE;
          end
        end else if (cond.expired) begin
          strb.setStatus = 1'b1; strb.statusVal = ST_TIMEOUT; nxt = S_DONE;
        end
      end
      S_DRN: begin
        strb.selRead = 1'b1;
        if (cond.ready) begin
          strb.rd = 1'b1; strb.incCnt = 1'b1; strb.pollRestart = 1'b1;
          if (cond.payLast) begin
            strb.setStatus = 1'b1; strb.statusVal = ST_MISMATCH; nxt = S_DONE;
          end
        end else if (cond.expired) begin
          strb.setStatus = 1'b1; strb.statusVal = ST_TIMEOUT; nxt = S_DONE;
        end
      end
      S_DONE: begin
        strb.pollRestart = 1'b1;
        nxt              = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/mbox_engine.sv
module mbox_engine
  import mbox_pkg::*;
#(
  parameter int POLL_CYC    = 1000,
  parameter int TIMEOUT_CYC = 5000000,
  parameter int RD_W        = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       reqOpcode,
  input  logic [7:0]       reqModule,
  input  logic [15:0]      reqLen,
  input  logic             waitReply,
  input  logic [7:0]       expOpcode,
  input  logic [7:0]       expModule,
  input  logic [15:0]      expLen,
  output logic [15:0]      txIdx,
  input  logic [7:0]       txData,
  input  logic             mbFull,
  output logic             mbWrEn,
  output logic [7:0]       mbWrData,
  input  logic             mbEmpty,
  output logic             mbRdEn,
  input  logic [RD_W-1:0]  mbRdData,
  output logic             rxValid,
  output logic [7:0]       rxByte,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status
);
  strobe_t strb;
  cond_t   cond;

  mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cond(cond),
    .strb(strb), .busy(busy), .done(done)
  );

  mbox_dpath #(
    .POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .RD_W(RD_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cond(cond),
    .reqOpcode(reqOpcode), .reqModule(reqModule), .reqLen(reqLen),
    .waitReply(waitReply), .expOpcode(expOpcode), .expModule(expModule),
    .expLen(expLen), .txIdx(txIdx), .txData(txData),
    .mbFull(mbFull), .mbWrEn(mbWrEn), .mbWrData(mbWrData),
    .mbEmpty(mbEmpty), .mbRdEn(mbRdEn), .mbRdData(mbRdData),
    .rxValid(rxValid), .rxByte(rxByte), .status(status)
  );
endmodule

// File: rtl/mbox_engine_chk.sv
module mbox_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic       mbFull,
  input logic       mbWrEn,
  input logic       mbEmpty,
  input logic       mbRdEn,
  input logic       rxValid
);
  a_r3_write_needs_room: assert property (@(posedge clk) disable iff (!rstN)
    mbWrEn |-> !mbFull);

  a_r4_read_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    mbRdEn |-> !mbEmpty);

  a_r5_stream_on_read: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> mbRdEn);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(mbWrEn || mbRdEn || rxValid));

  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(status));

  a_r10_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !(mbWrEn && mbRdEn));
endmodule

bind mbox_engine mbox_engine_chk u_chk (.*);

// File: tb/mbox_engine_test.sv
module mbox_engine_test;
  localparam int POLL = 4;
  localparam int TMO  = 40;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [7:0]  reqOpcode, reqModule, expOpcode, expModule;
  logic [15:0] reqLen, expLen;
  logic        waitReply;
  logic [15:0] txIdx;
  logic [7:0]  txData;
  logic        mbFull, mbEmpty;
  logic        mbWrEn, mbRdEn, rxValid, busy, done;
  logic [7:0]  mbWrData, rxByte;
  logic [31:0] mbRdData;
  logic [1:0]  status;

  always #2 clk = ~clk;

  mbox_engine #(.POLL_CYC(POLL), .TIMEOUT_CYC(TMO), .RD_W(32)) uut (.*);

  logic [7:0] txBuf [16];
  assign txData = (txIdx < 16'd16) ? txBuf[txIdx[3:0]] : 8'h00;

  logic [7:0] expWr[$];
  logic [7:0] expRx[$];
  logic [7:0] fromDev[$];
  int checks = 0, errors = 0;
  int stallLeft = 0;
  int rdTotal = 0;
  bit fullForce = 0, emptyForce = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic refreshMb();
    mbFull   = fullForce || (stallLeft > 0);
    mbEmpty  = emptyForce || (fromDev.size() == 0);
    mbRdData = {24'hA5C3E1, (fromDev.size() > 0) ? fromDev[0] : 8'h00};
  endtask

  // mailbox model and scoreboard monitor
  initial begin
    refreshMb();
    forever begin
      logic wrS, rdS, rvS;
      logic [7:0] wrD, rbD, e;
      @(negedge clk);
      wrS = mbWrEn; wrD = mbWrData; rdS = mbRdEn; rvS = rxValid; rbD = rxByte;
      if (wrS) begin
        if (expWr.size() == 0) chk(1'b0, "R2", "unexpected write", int'(wrD), 0);
        else begin
          e = expWr.pop_front();
          chk(wrD == e, "R1", "written byte", int'(wrD), int'(e));
        end
      end
      if (rvS) begin
        if (expRx.size() == 0) chk(1'b0, "R6", "unexpected rxValid", int'(rbD), 0);
        else begin
          e = expRx.pop_front();
          chk(rbD == e, "R5", "streamed byte", int'(rbD), int'(e));
        end
      end
      @(posedge clk);
      #1;
      if (rdS && fromDev.size() > 0) begin
        void'(fromDev.pop_front());
        rdTotal++;
      end
      if (stallLeft > 0) stallLeft--;
      refreshMb();
    end
  end

  task automatic setReq(input logic [7:0] op, input logic [7:0] md, input int len,
                        input bit rep);
    reqOpcode = op; reqModule = md; reqLen = 16'(len); waitReply = rep;
    expWr.push_back(op); expWr.push_back(md);
    expWr.push_back(8'(len >> 8)); expWr.push_back(8'(len));
    for (int i = 0; i < len; i++) expWr.push_back(txBuf[i]);
  endtask

  task automatic setExp(input logic [7:0] op, input logic [7:0] md, input int len);
    expOpcode = op; expModule = md; expLen = 16'(len);
  endtask

  task automatic devHdr(input logic [7:0] op, input logic [7:0] md, input int len);
    fromDev.push_back(op); fromDev.push_back(md);
    fromDev.push_back(8'(len >> 8)); fromDev.push_back(8'(len));
    refreshMb();
  endtask

  task automatic devByte(input logic [7:0] b, input bit toCaller);
    fromDev.push_back(b);
    if (toCaller) expRx.push_back(b);
    refreshMb();
  endtask

  task automatic run(input logic [1:0] expSt, input string tag, output int cyc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R9", "done seen", int'(done), 1);
    chk(status == expSt, tag, "status", int'(status), int'(expSt));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done single pulse, idle", int'({done, busy}), 0);
    chk(status == expSt, "R9", "status held", int'(status), int'(expSt));
    if (expSt == 2'd2) begin
      expWr.delete();
      expRx.delete();
    end else begin
      chk(expWr.size() == 0, "R2", "bytes still expected", expWr.size(), 0);
      chk(expRx.size() == 0, "R5", "reply bytes missing", expRx.size(), 0);
    end
  endtask

  initial begin
    int cyc, rd0;
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    rstN = 1'b0; start = 1'b0;
    setExp(8'h00, 8'h00, 0);
    reqOpcode = 8'h00; reqModule = 8'h00; reqLen = 16'h0; waitReply = 1'b0;
    for (int i = 0; i < 16; i++) txBuf[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(!busy && !done && !mbWrEn && !mbRdEn && !rxValid, "R9", "reset outputs quiet",
        int'({busy, done, mbWrEn, mbRdEn, rxValid}), 0);
    chk(status == 2'd0, "R9", "reset status", int'(status), 0);
    rstN = 1'b1;
    @(negedge clk);

    // register-write style request, no reply
    {txBuf[0], txBuf[1], txBuf[2], txBuf[3], txBuf[4], txBuf[5]} =
      {8'h12, 8'h34, 8'hDE, 8'hAD, 8'hBE, 8'hEF};
    rd0 = rdTotal;
    setReq(8'h05, 8'h01, 6, 1'b0);
    run(2'd0, "R10", cyc);
    chk(rdTotal == rd0, "R10", "no reads without reply", rdTotal - rd0, 0);
    chk(cyc <= 14, "R2", "back-to-back writes", cyc, 14);

    // matching reply, payload streamed
    {txBuf[0], txBuf[1], txBuf[2], txBuf[3], txBuf[4]} = {8'h00, 8'h01, 8'h00, 8'h20, 8'h00};
    setReq(8'h0A, 8'h01, 5, 1'b1);
    setExp(8'h0A, 8'h01, 3);
    devHdr(8'h0A, 8'h01, 3);
    devByte(8'h11, 1); devByte(8'h22, 1); devByte(8'h33, 1);
    run(2'd0, "R5", cyc);
    chk(fromDev.size() == 0, "R4", "reply fully consumed", fromDev.size(), 0);

    // opcode mismatch: drain by received length
    setReq(8'h0A, 8'h01, 0, 1'b1);
    setExp(8'h0A, 8'h01, 3);
    devHdr(8'h0B, 8'h01, 3);
    devByte(8'h44, 0); devByte(8'h55, 0); devByte(8'h66, 0); devByte(8'h77, 0);
    run(2'd1, "R6", cyc);
    chk(fromDev.size() == 1 && fromDev[0] == 8'h77, "R6", "drain stops at received length",
        fromDev.size(), 1);
    fromDev.delete(); refreshMb();

    // length mismatch: received length shorter than expected
    setReq(8'h0A, 8'h01, 0, 1'b1);
    setExp(8'h0A, 8'h01, 3);
    devHdr(8'h0A, 8'h01, 2);
    devByte(8'hAA, 0); devByte(8'hBB, 0); devByte(8'h5E, 0);
    run(2'd1, "R6", cyc);
    chk(fromDev.size() == 1, "R6", "length mismatch drain count", fromDev.size(), 1);
    fromDev.delete(); refreshMb();

    // module mismatch with zero received length: nothing drained
    setReq(8'h0A, 8'h01, 0, 1'b1);
    setExp(8'h0A, 8'h01, 0);
    devHdr(8'h0A, 8'h02, 0);
    devByte(8'h99, 0);
    run(2'd1, "R6", cyc);
    chk(fromDev.size() == 1, "R6", "zero-length mismatch reads header only", fromDev.size(), 1);
    fromDev.delete(); refreshMb();

    // zero-length request with zero-length matching reply
    setReq(8'h09, 8'h01, 0, 1'b1);
    setExp(8'h09, 8'h01, 0);
    devHdr(8'h09, 8'h01, 0);
    run(2'd0, "R5", cyc);

    // full mailbox stalls writes
    {txBuf[0], txBuf[1]} = {8'hC1, 8'hC2};
    setReq(8'h07, 8'h03, 2, 1'b0);
    stallLeft = 13; refreshMb();
    run(2'd0, "R3", cyc);
    chk(cyc >= 13, "R3", "write waited for room", cyc, 13);

    // write timeout
    fullForce = 1; refreshMb();
    setReq(8'h05, 8'h01, 1, 1'b0);
    run(2'd2, "R7", cyc);
    chk(cyc >= TMO, "R7", "timeout not early", cyc, TMO);
    chk(cyc <= TMO + POLL + 4, "R7", "timeout not late", cyc, TMO + POLL + 4);
    fullForce = 0; refreshMb();

    // read timeout: no reply arrives
    setReq(8'h0D, 8'h01, 0, 1'b1);
    setExp(8'h0D, 8'h01, 1);
    run(2'd2, "R7", cyc);
    chk(cyc >= TMO, "R7", "read timeout not early", cyc, TMO);

    // drain that times out, then a normal request
    setReq(8'h0A, 8'h01, 0, 1'b1);
    setExp(8'h0A, 8'h01, 5);
    devHdr(8'h0C, 8'h01, 5);
    devByte(8'h01, 0); devByte(8'h02, 0);
    run(2'd2, "R8", cyc);
    chk(fromDev.size() == 0, "R8", "partial drain consumed", fromDev.size(), 0);
    setReq(8'h0E, 8'h01, 0, 1'b1);
    setExp(8'h0E, 8'h01, 1);
    devHdr(8'h0E, 8'h01, 1);
    devByte(8'h3C, 1);
    run(2'd0, "R8", cyc);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule